// File: doc/BRIEF.md
# Register-Driven Flash Access Controller

This block turns accesses to three small registers into operations on an on-chip flash array. It sits behind a debug-port register interface. A control register holds a sector select bit, a write-mode field and a read-mode field. An address register points at a byte. A data register is where data is written and read, and accessing it is what starts operations. Writing the data register can program a byte, erase a page or erase the whole user area, depending on the write mode. Reading the data register can launch a byte read, either on every read or only when the previous result has already been taken.

Program and erase run for a fixed number of cycles, set by parameters. A read runs for one cycle. While any operation runs, the block reports busy, and new requests that arrive in that time are dropped. When a read finishes, its byte lands in the data register and a valid flag is raised. The next read of the data register returns that byte and clears the flag.

The array is behavioural. Programming can only clear bits. Erasure sets bytes to 0xFF. The top `RSV_BYTES` of the main array are protected from program and erase. Setting the select bit sends every operation to a small separate scratchpad sector.

Top module: `fac_top`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: control, address and data registers, busy and read-valid. Every array byte reads 0xFF. Register select: 0 is control, 1 is address, 2 is data. Control bit 7 selects the scratchpad, bits 6:4 hold the write mode and bits 3:0 hold the read mode. Read data is zero-extended to 16 bits.
- R2: With write mode 000, a data-register write only loads the low byte into the data register, and busy stays low.
- R3: With write mode 001, a data-register write programs the byte at the address as (old AND data). Busy is high for exactly `PROG_CYCLES` cycles, and the address register then holds the operation's address plus one.
- R4: With write mode 010 and written data 0xA5, the page of `PAGE_BYTES` bytes that holds the address is set to 0xFF. Busy lasts `ERASE_CYCLES` cycles and the address is unchanged. Any other data value starts nothing.
- R5: An erase with a main-array address of RSV_BASE-2 or RSV_BASE-1 sets every main byte below RSV_BASE to 0xFF, where RSV_BASE is the array size minus `RSV_BYTES`.
- R6: A program or erase aimed at a main-array address at or above RSV_BASE is ignored. Busy stays low, and neither the address nor the memory changes.
- R7: With read mode 0000, a data-register read returns the data register and starts nothing.
- R8: With read mode 0001, a data-register read made while idle returns the current data register and starts a one-cycle read. Afterwards the data register holds the addressed byte and read-valid is 1.
- R9: With read mode 0010, a data-register read starts a read only if the block is idle and read-valid is 0. Any data-register read clears read-valid.
- R10: Write-mode codes 011 to 111 and read-mode codes 0011 to 1111 start no operation.
- R11: Program, erase and read requests made while busy are dropped.
- R12: With the select bit set, operations use a 128-byte scratchpad addressed by the low 7 address bits, and the main array is not touched. An erase clears the whole scratchpad, and the reserved-region rule does not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| busy | output | 1 | An operation is running |
| rd_valid | output | 1 | A read result is waiting in the data register |

## Verification
The bench builds the block with an 11-bit address, 512-byte pages and a 512-byte reserved top page. This gives three user pages and puts the mass-erase key addresses at 0x5FE and 0x5FF, inside a 2 KB model. `PROG_CYCLES`=4 and `ERASE_CYCLES`=9 are short enough that the exact busy length can be counted. The program length is still long enough for a second request to land inside the busy window. A 128-byte scratchpad lets the sector switch, the whole-sector erase and the top scratch address all be reached.

// File: rtl/fac_pkg.sv
// Package: shared constants and operation codes for the flash access controller.
// Assumes the register bus is 16 bits and the address width never exceeds it.
package fac_pkg;

    localparam int BUS_W = 16;

    // Register select codes
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    // Write-mode field codes (control bits 6:4)
    localparam logic [2:0] WM_LOAD  = 3'b000;
    localparam logic [2:0] WM_PROG  = 3'b001;
    localparam logic [2:0] WM_ERASE = 3'b010;

    // Read-mode field codes (control bits 3:0)
    localparam logic [3:0] RM_PLAIN  = 4'b0000;
    localparam logic [3:0] RM_STREAM = 4'b0001;
    localparam logic [3:0] RM_ONCE   = 4'b0010;

    localparam logic [7:0] ERASE_KEY = 8'hA5;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_PROG  = 3'd2,
        OP_ERASE = 3'd3,
        OP_MASS  = 3'd4
    } op_e;

endpackage

// File: rtl/fac_decode.sv
// Module: fac_decode
// Decides which flash operation, if any, a data-register access starts.
// The decision uses the control fields, the address, busy and read-valid.
// Assumes a write and a read in the same cycle give priority to the write.
module fac_decode
    import fac_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int RSV_BYTES = 512
) (
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [7:0]        wbyte,
    input  logic [7:0]        ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              rd_valid,
    output logic              start,
    output op_e               start_op
);

    localparam int unsigned MAIN_BYTES = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] RSV_BASE = ADDR_W'(MAIN_BYTES - RSV_BYTES);
    localparam logic [ADDR_W-1:0] MASS_LO  = RSV_BASE - ADDR_W'(2);
    localparam logic [ADDR_W-1:0] MASS_HI  = RSV_BASE - ADDR_W'(1);

    logic       scr;
    logic [2:0] wm;
    logic [3:0] rm;
    logic       in_rsv;
    logic       mass_hit;

    assign scr      = ctrl[7];
    assign wm       = ctrl[6:4];
    assign rm       = ctrl[3:0];
    assign in_rsv   = !scr && (addr >= RSV_BASE);
    assign mass_hit = !scr && ((addr == MASS_LO) || (addr == MASS_HI));

    // Map the access and mode fields onto one operation request.
    always_comb begin
        start_op = OP_NONE;
        if (!busy) begin
            if (data_wr) begin
                case (wm)
                    WM_PROG:  if (!in_rsv) start_op = OP_PROG;
                    WM_ERASE: if (!in_rsv && wbyte == ERASE_KEY)
                                  start_op = mass_hit ? OP_MASS : OP_ERASE;
                    default:  start_op = OP_NONE;
                endcase
            end else if (data_rd) begin
                case (rm)
                    RM_STREAM: start_op = OP_READ;
                    RM_ONCE:   if (!rd_valid) start_op = OP_READ;
                    default:   start_op = OP_NONE;
                endcase
            end
        end
    end

    assign start = (start_op != OP_NONE);

endmodule

// File: rtl/fac_seq.sv
// Module: fac_seq
// Operation sequencer. It latches an accepted request and holds busy for the
// length of that operation type, then raises done for the last busy cycle.
// Assumes the caller never asserts start while busy is high.
module fac_seq
    import fac_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic              start_scr,
    output logic              busy,
    output logic              done,
    output op_e               op,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              op_scr
);

    localparam int MAX_LEN = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_len;

    // Cycles remaining after the first busy cycle, per operation type.
    always_comb begin
        case (start_op)
            OP_PROG:          load_len = CNT_W'(PROG_CYCLES - 1);
            OP_ERASE, OP_MASS: load_len = CNT_W'(ERASE_CYCLES - 1);
            default:          load_len = '0;
        endcase
    end

    // Capture a request and count down its busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            op      <= OP_NONE;
            op_addr <= '0;
            op_data <= '0;
            op_scr  <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            cnt     <= load_len;
            op      <= start_op;
            op_addr <= start_addr;
            op_data <= start_data;
            op_scr  <= start_scr;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R11
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_op == OP_READ) |=> done); // R8

endmodule

// File: rtl/fac_array.sv
// Module: fac_array
// Behavioural flash storage: a main array and a scratchpad sector.
// It applies program (bitwise AND), page erase, mass erase and scratch erase
// at the completion pulse, and reads combinationally at the operation address.
// Assumes the sequencer only completes operations the decoder has already
// checked against the reserved region. Contents start erased on reset.
module fac_array
    import fac_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 512,
    parameter int RSV_BYTES  = 512,
    parameter int SCR_BYTES  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_e               op,
    input  logic              scr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rbyte
);

    localparam int unsigned MAIN_BYTES = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] RSV_BASE = ADDR_W'(MAIN_BYTES - RSV_BYTES);
    localparam int PG_SH  = $clog2(PAGE_BYTES);
    localparam int SCR_AW = $clog2(SCR_BYTES);

    logic [7:0] main_mem [MAIN_BYTES];
    logic [7:0] scr_mem  [SCR_BYTES];
    logic [SCR_AW-1:0] scr_idx;

    assign scr_idx = addr[SCR_AW-1:0];

    // Main array: erased on reset, updated on completion when not in scratch mode.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(MAIN_BYTES); i++) begin
            if (!rst_n) begin
                main_mem[i] <= 8'hFF;
            end else if (commit && !scr) begin
                case (op)
                    OP_PROG:  if (ADDR_W'(i) == addr) main_mem[i] <= main_mem[i] & wdata;
                    OP_ERASE: if ((ADDR_W'(i) >> PG_SH) == (addr >> PG_SH)) main_mem[i] <= 8'hFF;
                    OP_MASS:  if (ADDR_W'(i) < RSV_BASE) main_mem[i] <= 8'hFF;
                    default:  ;
                endcase
            end
        end
    end

    // Scratchpad: erased on reset, any erase clears the whole sector.
    always_ff @(posedge clk) begin
        for (int j = 0; j < SCR_BYTES; j++) begin
            if (!rst_n) begin
                scr_mem[j] <= 8'hFF;
            end else if (commit && scr) begin
                case (op)
                    OP_PROG:          if (SCR_AW'(j) == scr_idx) scr_mem[j] <= scr_mem[j] & wdata;
                    OP_ERASE, OP_MASS: scr_mem[j] <= 8'hFF;
                    default:          ;
                endcase
            end
        end
    end

    // Combinational read at the operation address.
    assign rbyte = scr ? scr_mem[scr_idx] : main_mem[addr];

    AST_RSV_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !scr && (op == OP_PROG || op == OP_ERASE)) |-> (addr < RSV_BASE)); // R6

endmodule

// File: rtl/fac_top.sv
// Module: fac_top
// Flash access controller top. It holds the control, address and data
// registers and the read-valid flag, and wires decoder, sequencer and array.
// Assumes one register access per strobe cycle and ADDR_W <= 16.
module fac_top
    import fac_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BYTES   = 512,
    parameter int RSV_BYTES    = 512,
    parameter int SCR_BYTES    = 128,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             busy,
    output logic             rd_valid
);

    logic [7:0]        ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              valid_q;

    logic              data_wr;
    logic              data_rd;
    logic              start;
    op_e               start_op;
    logic              seq_busy;
    logic              seq_done;
    op_e               seq_op;
    logic [ADDR_W-1:0] seq_addr;
    logic [7:0]        seq_data;
    logic              seq_scr;
    logic [7:0]        arr_byte;

    assign data_wr = reg_wr && (reg_sel == SEL_DATA);
    assign data_rd = reg_rd && (reg_sel == SEL_DATA);

    fac_decode #(
        .ADDR_W    (ADDR_W),
        .RSV_BYTES (RSV_BYTES)
    ) u_decode (
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .wbyte    (reg_wdata[7:0]),
        .ctrl     (ctrl_q),
        .addr     (addr_q),
        .busy     (seq_busy),
        .rd_valid (valid_q),
        .start    (start),
        .start_op (start_op)
    );

    fac_seq #(
        .ADDR_W       (ADDR_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (start_op),
        .start_addr (addr_q),
        .start_data (reg_wdata[7:0]),
        .start_scr  (ctrl_q[7]),
        .busy       (seq_busy),
        .done       (seq_done),
        .op         (seq_op),
        .op_addr    (seq_addr),
        .op_data    (seq_data),
        .op_scr     (seq_scr)
    );

    fac_array #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .RSV_BYTES  (RSV_BYTES),
        .SCR_BYTES  (SCR_BYTES)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (seq_done),
        .op     (seq_op),
        .scr    (seq_scr),
        .addr   (seq_addr),
        .wdata  (seq_data),
        .rbyte  (arr_byte)
    );

    // Control register: plain load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (reg_wr && reg_sel == SEL_CTRL)  ctrl_q <= reg_wdata[7:0];
    end

    // Address register: post-program increment wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              addr_q <= '0;
        else if (seq_done && seq_op == OP_PROG)  addr_q <= seq_addr + 1'b1;
        else if (reg_wr && reg_sel == SEL_ADDR)  addr_q <= reg_wdata[ADDR_W-1:0];
    end

    // Data register: a completed read wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              data_q <= '0;
        else if (seq_done && seq_op == OP_READ)  data_q <= arr_byte;
        else if (data_wr)                        data_q <= reg_wdata[7:0];
    end

    // Read-valid flag: set by read completion, cleared by a data-register read.
    always_ff @(posedge clk) begin
        if (!rst_n)                              valid_q <= 1'b0;
        else if (seq_done && seq_op == OP_READ)  valid_q <= 1'b1;
        else if (data_rd)                        valid_q <= 1'b0;
    end

    // Read mux for the register interface.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = BUS_W'(ctrl_q);
            SEL_ADDR: reg_rdata = BUS_W'(addr_q);
            SEL_DATA: reg_rdata = BUS_W'(data_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign busy     = seq_busy;
    assign rd_valid = valid_q;

    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_op == OP_READ) |=> valid_q); // R8
    AST_ADDR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_op == OP_PROG) |=> (addr_q == $past(seq_addr) + 1'b1)); // R3
    AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !seq_busy && ctrl_q[6:4] == WM_ERASE && reg_wdata[7:0] != ERASE_KEY)
        |=> !seq_busy); // R4
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !seq_busy && ctrl_q[6:4] == WM_LOAD) |=> !seq_busy); // R2
    AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !seq_busy && ctrl_q[6:4] > WM_ERASE) |=> !seq_busy); // R10

endmodule

// File: tb/fac_top_test.sv
// Scoreboard bench for fac_top. Driver tasks push the expected read data;
// a monitor pops and compares it in the middle of each read strobe cycle.
module fac_top_test;

    localparam int ADDR_W = 11;
    localparam int PROG_N = 4;
    localparam int ERASE_N = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_q [$];
    bit          chk_q [$];
    string       tag_q [$];

    fac_top #(
        .ADDR_W       (ADDR_W),
        .PAGE_BYTES   (512),
        .RSV_BYTES    (512),
        .SCR_BYTES    (128),
        .PROG_CYCLES  (PROG_N),
        .ERASE_CYCLES (ERASE_N)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .rd_valid  (rd_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] ctl(input logic s, input logic [2:0] w, input logic [3:0] r);
        return {8'h00, s, w, r};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic r, input logic [1:0] s, input logic [15:0] d);
        @(posedge clk); #2;
        reg_wr = w; reg_rd = r; reg_sel = s; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        access(1'b1, 1'b0, s, d);
    endtask

    task automatic rd(input logic [1:0] s, input logic [15:0] exp, input bit chk, input string tag);
        exp_q.push_back(exp); chk_q.push_back(chk); tag_q.push_back(tag);
        access(1'b0, 1'b1, s, 16'h0);
    endtask

    task automatic wait_idle();
        while (busy) begin @(posedge clk); #2; end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin @(posedge clk); #2; n++; end
    endtask

    task automatic peek(input logic s, input logic [15:0] a, input logic [7:0] exp, input string tag);
        wr(2'd0, ctl(s, 3'b000, 4'b0001));
        wr(2'd1, a);
        rd(2'd2, 16'h0, 1'b0, tag);
        wait_idle();
        wr(2'd0, ctl(s, 3'b000, 4'b0000));
        rd(2'd2, {8'h00, exp}, 1'b1, tag);
    endtask

    task automatic prog(input logic s, input logic [15:0] a, input logic [7:0] d);
        wr(2'd0, ctl(s, 3'b001, 4'b0000));
        wr(2'd1, a);
        wr(2'd2, {8'h00, d});
        wait_idle();
    endtask

    // Monitor: pop one expected item per read strobe and compare mid-cycle.
    always @(negedge clk) begin
        if (reg_rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%h expected=queued item", reg_rdata);
            end else begin
                logic [15:0] e;
                bit c;
                string t;
                e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
                if (c) check(t, reg_rdata, e);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        check("R1 busy", {15'h0, busy}, 16'h0);
        check("R1 valid", {15'h0, rd_valid}, 16'h0);
        rd(2'd0, 16'h0000, 1'b1, "R1 ctrl");
        rd(2'd1, 16'h0000, 1'b1, "R1 addr");
        rd(2'd2, 16'h0000, 1'b1, "R1 data");
        peek(1'b0, 16'h000, 8'hFF, "R1 erased");

        // R2 load only, R7 plain read
        wr(2'd0, ctl(1'b0, 3'b000, 4'b0000));
        wr(2'd2, 16'h003C);
        check("R2 no op", {15'h0, busy}, 16'h0);
        rd(2'd2, 16'h003C, 1'b1, "R2 R7 data");
        check("R7 no op", {15'h0, busy}, 16'h0);

        // R3 program with AND and increment
        wr(2'd0, ctl(1'b0, 3'b001, 4'b0000));
        wr(2'd1, 16'h010);
        wr(2'd2, 16'h00F0);
        count_busy(n);
        check("R3 busy len", 16'(n), 16'(PROG_N));
        rd(2'd1, 16'h0011, 1'b1, "R3 addr inc");
        prog(1'b0, 16'h010, 8'h3C);
        peek(1'b0, 16'h010, 8'h30, "R3 and");

        // R11 second program during busy is dropped
        wr(2'd0, ctl(1'b0, 3'b001, 4'b0000));
        wr(2'd1, 16'h020);
        wr(2'd2, 16'h0011);
        wr(2'd2, 16'h0022);
        wait_idle();
        rd(2'd1, 16'h0021, 1'b1, "R11 addr");
        peek(1'b0, 16'h021, 8'hFF, "R11 untouched");
        peek(1'b0, 16'h020, 8'h11, "R11 first kept");

        // R4 page erase with and without key
        prog(1'b0, 16'h200, 8'h12);
        prog(1'b0, 16'h400, 8'h34);
        wr(2'd0, ctl(1'b0, 3'b010, 4'b0000));
        wr(2'd1, 16'h3FF);
        wr(2'd2, 16'h005A);
        check("R4 bad key", {15'h0, busy}, 16'h0);
        peek(1'b0, 16'h200, 8'h12, "R4 bad key kept");
        wr(2'd0, ctl(1'b0, 3'b010, 4'b0000));
        wr(2'd1, 16'h3FF);
        wr(2'd2, 16'h00A5);
        count_busy(n);
        check("R4 busy len", 16'(n), 16'(ERASE_N));
        rd(2'd1, 16'h03FF, 1'b1, "R4 addr kept");
        peek(1'b0, 16'h200, 8'hFF, "R4 page erased");
        peek(1'b0, 16'h400, 8'h34, "R4 other page");

        // R6 reserved region protection
        wr(2'd0, ctl(1'b0, 3'b001, 4'b0000));
        wr(2'd1, 16'h600);
        wr(2'd2, 16'h0000);
        check("R6 prog ignored", {15'h0, busy}, 16'h0);
        rd(2'd1, 16'h0600, 1'b1, "R6 addr");
        peek(1'b0, 16'h600, 8'hFF, "R6 byte");
        wr(2'd0, ctl(1'b0, 3'b010, 4'b0000));
        wr(2'd1, 16'h7FF);
        wr(2'd2, 16'h00A5);
        check("R6 erase ignored", {15'h0, busy}, 16'h0);

        // R10 reserved codes
        wr(2'd0, ctl(1'b0, 3'b011, 4'b0000));
        wr(2'd1, 16'h100);
        wr(2'd2, 16'h0000);
        check("R10 wmode", {15'h0, busy}, 16'h0);
        peek(1'b0, 16'h100, 8'hFF, "R10 byte");
        wr(2'd0, ctl(1'b0, 3'b000, 4'b0011));
        rd(2'd2, 16'h0, 1'b0, "R10 rmode");
        check("R10 rmode busy", {15'h0, busy}, 16'h0);
        check("R10 rmode valid", {15'h0, rd_valid}, 16'h0);

        // R8 streaming read
        prog(1'b0, 16'h030, 8'h77);
        wr(2'd0, ctl(1'b0, 3'b000, 4'b0000));
        wr(2'd2, 16'h0099);
        wr(2'd0, ctl(1'b0, 3'b000, 4'b0001));
        wr(2'd1, 16'h030);
        rd(2'd2, 16'h0099, 1'b1, "R8 old data");
        check("R8 busy", {15'h0, busy}, 16'h1);
        @(posedge clk); #2;
        check("R8 done", {15'h0, busy}, 16'h0);
        check("R8 valid", {15'h0, rd_valid}, 16'h1);
        rd(2'd2, 16'h0077, 1'b1, "R8 byte");
        wait_idle();

        // R9 conditional read
        wr(2'd0, ctl(1'b0, 3'b000, 4'b0010));
        rd(2'd2, 16'h0077, 1'b1, "R9 take");
        check("R9 no launch", {15'h0, busy}, 16'h0);
        check("R9 cleared", {15'h0, rd_valid}, 16'h0);
        rd(2'd2, 16'h0077, 1'b1, "R9 stale");
        check("R9 launch", {15'h0, busy}, 16'h1);
        wait_idle();
        check("R9 valid", {15'h0, rd_valid}, 16'h1);

        // R5 mass erase
        prog(1'b0, 16'h000, 8'h01);
        prog(1'b0, 16'h250, 8'h02);
        prog(1'b0, 16'h5FD, 8'h03);
        wr(2'd0, ctl(1'b0, 3'b010, 4'b0000));
        wr(2'd1, 16'h5FF);
        wr(2'd2, 16'h00A5);
        count_busy(n);
        check("R5 busy len", 16'(n), 16'(ERASE_N));
        peek(1'b0, 16'h000, 8'hFF, "R5 low");
        peek(1'b0, 16'h250, 8'hFF, "R5 mid");
        peek(1'b0, 16'h5FD, 8'hFF, "R5 top");

        // R12 scratchpad
        prog(1'b1, 16'h005, 8'h5A);
        rd(2'd1, 16'h0006, 1'b1, "R12 addr inc");
        prog(1'b1, 16'h07F, 8'h0F);
        peek(1'b1, 16'h005, 8'h5A, "R12 scratch byte");
        peek(1'b1, 16'h07F, 8'h0F, "R12 scratch top");
        peek(1'b0, 16'h005, 8'hFF, "R12 main untouched");
        wr(2'd0, ctl(1'b1, 3'b010, 4'b0000));
        wr(2'd1, 16'h010);
        wr(2'd2, 16'h00A5);
        wait_idle();
        peek(1'b1, 16'h005, 8'hFF, "R12 sector erased");
        peek(1'b1, 16'h07F, 8'hFF, "R12 sector erased top");

        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule